// File: doc/BRIEF.md
# Translating Lookaside Buffer with Access Rights Check

This block caches page translations for a single access stream, either instruction fetches or data accesses. A 32-bit logical address presented on the lookup port is compared against every stored entry in the same cycle. On a hit, the block returns the 36-bit physical address, the cacheable attribute of the page, and a fault code that reports whether the access breaks the page's write, execute or user-mode permissions. On a miss, the surrounding hardware table walker fetches the descriptor and loads it through the refill port. Each entry maps either a 4 KB page or a 4 MB page.

Software maintenance requests arrive as two commands. The flush command is issued on every context switch and drops every entry that is not marked global. The single-line invalidate command drops the entries that translate one given logical address, whether or not they are global. When the enable input is low, lookups pass through untranslated. The update commands still act on the stored entries while the block is disabled. Refill victims are chosen among the free entries first. When the buffer is full, a round-robin pointer picks the victim.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so an enabled lookup reports miss=1 and hit=0.
- R2: A 4 KB entry matches when its stored VA[31:12] equals the lookup VA[31:12], and the hit returns paddr = {PPN[23:0], VA[11:0]}.
- R3: A 4 MB entry (rf_big=1) matches on VA[31:22] alone, and the hit returns paddr = {PPN[23:10], VA[21:0]}.
- R4: With en=1 and lk_req=1, exactly one of hit and miss is high. With lk_req=0, both are low. When several entries match, the lowest-numbered entry supplies the result. On a miss with en=1, paddr is zero.
- R5: On a hit, fault is 3 for a user-mode access (lk_user=1) to a page with U=0. Otherwise it is 1 for a write (lk_write=1) to a page with W=0. Otherwise it is 2 for a fetch (lk_exec=1) from a page with X=0. Otherwise it is 0. A miss always gives fault 0.
- R6: cacheable equals the C bit of the hit entry, and it is 0 whenever hit is 0.
- R7: With en=0, hit, miss, fault and cacheable are all 0, and paddr = {4'h0, VA}.
- R8: A flush leaves valid only the entries whose G bit is set. The change takes effect at the next clock edge.
- R9: An invalidate removes every valid entry that matches inv_vaddr under the rules of R2/R3, including global ones, and leaves the other entries unchanged.
- R10: A refill writes into the lowest-numbered invalid entry. If every entry is valid, the refill writes into the entry selected by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping from 7 to 0, on each refill made while the buffer is full.
- R11: At most one update happens per cycle, with priority flush, then invalidate, then refill. A lower-priority command issued in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Translation enable; low gives pass-through |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup logical address |
| lk_user | input | 1 | Access made in user mode |
| lk_write | input | 1 | Access is a write |
| lk_exec | input | 1 | Access is an instruction fetch |
| rf_valid | input | 1 | Refill command |
| rf_vaddr | input | 32 | Logical address of the refilled page |
| rf_big | input | 1 | 1 = 4 MB page, 0 = 4 KB page |
| rf_ppn | input | 24 | Physical page number |
| rf_c | input | 1 | Cacheable attribute |
| rf_w | input | 1 | Writable attribute |
| rf_x | input | 1 | Executable attribute |
| rf_u | input | 1 | User access allowed attribute |
| rf_g | input | 1 | Global attribute (survives flush) |
| rf_d | input | 1 | Dirty attribute |
| inv_valid | input | 1 | Single-line invalidate command |
| inv_vaddr | input | 32 | Address to invalidate |
| flush | input | 1 | Flush all non-global entries |
| hit | output | 1 | Lookup hit |
| miss | output | 1 | Lookup miss |
| paddr | output | 36 | Physical address |
| cacheable | output | 1 | Cacheable flag of the hit page |
| fault | output | 2 | Access fault code |

## Verification
The hardest situation to reach is round-robin replacement in a buffer whose free slots are opened and closed by invalidates and flushes. In that situation the victim switches between the lowest free slot and the pointer, and global entries survive the flush. Random stimulus draws addresses from a small pool of 4 MB regions and 4 KB pages. This keeps the buffer full most of the time and makes entries of both sizes overlap. Directed sequences fill the buffer past capacity, flush around a global entry, and issue conflicting commands in the same cycle. A bench model tracks every slot and the pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 36;
  localparam int PPN_W = 24;
  localparam int VPN_W = VA_W - 12;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_WRITE = 2'd1,
    FLT_EXEC  = 2'd2,
    FLT_USER  = 2'd3
  } fault_e;

  typedef struct packed {
    logic c;
    logic w;
    logic x;
    logic u;
    logic g;
    logic d;
  } attr_t;

  typedef struct packed {
    logic             big;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    attr_t            attr;
  } entry_t;

  // Tag compare: large pages use only the upper ten bits of the page number.
  function automatic logic tag_match(entry_t e, logic [VA_W-1:0] va);
    if (e.big) return e.vpn[VPN_W-1:VPN_W-10] == va[VA_W-1:22];
    return e.vpn == va[VA_W-1:12];
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(entry_t e, logic [VA_W-1:0] va);
    if (e.big) return {e.ppn[PPN_W-1:10], va[21:0]};
    return {e.ppn, va[11:0]};
  endfunction

  // Priority: user privilege, then write protection, then execute protection.
  function automatic fault_e rights(attr_t a, logic user, logic wr, logic ex);
    if (user && !a.u) return FLT_USER;
    if (wr && !a.w)   return FLT_WRITE;
    if (ex && !a.x)   return FLT_EXEC;
    return FLT_NONE;
  endfunction
endpackage

// File: rtl/tlb_first.sv
module tlb_first #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] oh,
  output logic         any
);
  logic found;
  always_comb begin
    oh    = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        oh[i] = 1'b1;
        found = 1'b1;
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N = 8
) (
  input  entry_t [N-1:0]    ents,
  input  logic   [N-1:0]    vld,
  input  logic   [VA_W-1:0] va,
  output logic   [N-1:0]    m
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign m[g] = vld[g] && tag_match(ents[g], va);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] vld,
  input  logic         advance,
  output logic [N-1:0] victim_oh,
  output logic         full
);
  logic [N-1:0]  free_oh;
  logic          any_free;
  logic [IW-1:0] rr_q;

  tlb_first #(.N(N)) u_free (
    .req (~vld),
    .oh  (free_oh),
    .any (any_free)
  );

  assign full      = !any_free;
  assign victim_oh = any_free ? free_oh : (N'(1) << rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance && full) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        lk_req,
  input  logic [31:0] lk_vaddr,
  input  logic        lk_user,
  input  logic        lk_write,
  input  logic        lk_exec,
  input  logic        rf_valid,
  input  logic [31:0] rf_vaddr,
  input  logic        rf_big,
  input  logic [23:0] rf_ppn,
  input  logic        rf_c,
  input  logic        rf_w,
  input  logic        rf_x,
  input  logic        rf_u,
  input  logic        rf_g,
  input  logic        rf_d,
  input  logic        inv_valid,
  input  logic [31:0] inv_vaddr,
  input  logic        flush,
  output logic        hit,
  output logic        miss,
  output logic [35:0] paddr,
  output logic        cacheable,
  output logic [1:0]  fault
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  entry_t [ENTRIES-1:0] ents_q;
  logic   [ENTRIES-1:0] vld_q;
  logic   [ENTRIES-1:0] glob_vec;
  logic   [ENTRIES-1:0] lk_match, inv_match, hit_oh, victim_oh;
  logic                 hit_any, tlb_full;
  logic                 flush_do, inv_do, fill_do;
  entry_t               sel_ent, new_ent;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_glob
    assign glob_vec[g] = ents_q[g].attr.g;
  end

  tlb_match #(.N(ENTRIES)) u_lk_match (
    .ents (ents_q), .vld (vld_q), .va (lk_vaddr), .m (lk_match)
  );

  tlb_match #(.N(ENTRIES)) u_inv_match (
    .ents (ents_q), .vld (vld_q), .va (inv_vaddr), .m (inv_match)
  );

  tlb_first #(.N(ENTRIES)) u_hit_pick (
    .req (lk_match), .oh (hit_oh), .any (hit_any)
  );

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_oh[i]) sel_ent = entry_t'(sel_ent | ents_q[i]);
    end
  end

  // Update command arbitration: flush over invalidate over refill.
  assign flush_do = flush;
  assign inv_do   = inv_valid && !flush;
  assign fill_do  = rf_valid && !flush && !inv_valid;

  tlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (vld_q),
    .advance   (fill_do),
    .victim_oh (victim_oh),
    .full      (tlb_full)
  );

  always_comb begin
    new_ent        = '0;
    new_ent.big    = rf_big;
    new_ent.vpn    = rf_vaddr[31:12];
    new_ent.ppn    = rf_ppn;
    new_ent.attr.c = rf_c;
    new_ent.attr.w = rf_w;
    new_ent.attr.x = rf_x;
    new_ent.attr.u = rf_u;
    new_ent.attr.g = rf_g;
    new_ent.attr.d = rf_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush_do) begin
      vld_q <= vld_q & glob_vec;
    end else if (inv_do) begin
      vld_q <= vld_q & ~inv_match;
    end else if (fill_do) begin
      vld_q <= vld_q | victim_oh;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (fill_do && victim_oh[g]) ents_q[g] <= new_ent;
    end
  end

  always_comb begin
    if (!en) begin
      hit       = 1'b0;
      miss      = 1'b0;
      paddr     = {4'h0, lk_vaddr};
      cacheable = 1'b0;
      fault     = FLT_NONE;
    end else begin
      hit       = lk_req && hit_any;
      miss      = lk_req && !hit_any;
      paddr     = hit_any ? phys_addr(sel_ent, lk_vaddr) : '0;
      cacheable = hit && sel_ent.attr.c;
      fault     = hit ? rights(sel_ent.attr, lk_user, lk_write, lk_exec) : FLT_NONE;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               lk_req,
  input logic [31:0]        lk_vaddr,
  input logic               hit,
  input logic               miss,
  input logic [35:0]        paddr,
  input logic [1:0]         fault,
  input logic               flush,
  input logic               inv_valid,
  input logic [ENTRIES-1:0] vld_q,
  input logic [ENTRIES-1:0] glob_vec,
  input logic [ENTRIES-1:0] victim_oh,
  input logic               fill_do
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hit && miss)); // R4
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n) (en && lk_req) |-> (hit || miss)); // R4
  AST_MISS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) miss |-> (fault == 2'd0)); // R5
  AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (!rst_n) !en |-> (!hit && !miss && paddr == {4'h0, lk_vaddr})); // R7
  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (vld_q == $past(vld_q & glob_vec))); // R8
  AST_VICTIM_ONE: assert property (@(posedge clk) disable iff (!rst_n) $countones(victim_oh) == 1); // R10
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n) fill_do |=> ((vld_q & $past(victim_oh)) != '0)); // R10
  AST_INV_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n) (inv_valid && !flush) |=> ((vld_q & ~$past(vld_q)) == '0)); // R11
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_tlb_xlate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .lk_req    (lk_req),
  .lk_vaddr  (lk_vaddr),
  .hit       (hit),
  .miss      (miss),
  .paddr     (paddr),
  .fault     (fault),
  .flush     (flush),
  .inv_valid (inv_valid),
  .vld_q     (vld_q),
  .glob_vec  (glob_vec),
  .victim_oh (victim_oh),
  .fill_do   (fill_do)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam int NE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, lk_req = 1'b0, lk_user = 1'b0, lk_write = 1'b0, lk_exec = 1'b0;
  logic [31:0] lk_vaddr = '0, rf_vaddr = '0, inv_vaddr = '0;
  logic rf_valid = 1'b0, rf_big = 1'b0, inv_valid = 1'b0, flush = 1'b0;
  logic [23:0] rf_ppn = '0;
  logic rf_c = 1'b0, rf_w = 1'b0, rf_x = 1'b0, rf_u = 1'b0, rf_g = 1'b0, rf_d = 1'b0;
  logic hit, miss, cacheable;
  logic [35:0] paddr;
  logic [1:0] fault;

  int total = 0;
  int fails = 0;

  // Bench model of the stored entries
  bit          mv [NE];
  bit [19:0]   mvpn [NE];
  bit          mbig [NE];
  bit [23:0]   mppn [NE];
  bit          mc [NE], mw [NE], mx [NE], mu [NE], mg [NE];
  int          rr = 0;

  always #4 clk = ~clk;

  tlb_xlate #(.ENTRIES(NE)) i_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .en(en), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_user(lk_user), .lk_write(lk_write), .lk_exec(lk_exec),
    .rf_valid(rf_valid), .rf_vaddr(rf_vaddr), .rf_big(rf_big), .rf_ppn(rf_ppn),
    .rf_c(rf_c), .rf_w(rf_w), .rf_x(rf_x), .rf_u(rf_u), .rf_g(rf_g), .rf_d(rf_d),
    .inv_valid(inv_valid), .inv_vaddr(inv_vaddr), .flush(flush),
    .hit(hit), .miss(miss), .paddr(paddr), .cacheable(cacheable), .fault(fault)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit mmatch(int i, logic [31:0] va);
    if (!mv[i]) return 1'b0;
    if (mbig[i]) return mvpn[i][19:10] == va[31:22];
    return mvpn[i] == va[31:12];
  endfunction

  function automatic int mlook(logic [31:0] va);
    for (int i = 0; i < NE; i++) if (mmatch(i, va)) return i;
    return -1;
  endfunction

  function automatic logic [35:0] mphys(int i, logic [31:0] va);
    logic [35:0] base;
    base = {mppn[i], 12'h000};
    if (mbig[i]) return (base & ~36'h3F_FFFF) | {14'h0, va[21:0]};
    return base | {24'h0, va[11:0]};
  endfunction

  function automatic logic [1:0] mfault(int i);
    if (lk_user && !mu[i]) return 2'd3;
    if (lk_write && !mw[i]) return 2'd1;
    if (lk_exec && !mx[i]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic model_check();
    int idx;
    bit h;
    idx = mlook(lk_vaddr);
    if (!en) begin
      chk("R7 hit", hit, 0);
      chk("R7 miss", miss, 0);
      chk("R7 paddr", paddr, {4'h0, lk_vaddr});
      chk("R7 cacheable", cacheable, 0);
      chk("R7 fault", fault, 0);
    end else begin
      h = lk_req && idx >= 0;
      chk("R4 hit", hit, h);
      chk("R4 miss", miss, lk_req && idx < 0);
      if (idx >= 0) chk(mbig[idx] ? "R3 paddr" : "R2 paddr", paddr, mphys(idx, lk_vaddr));
      else chk("R4 paddr", paddr, 0);
      chk("R6 cacheable", cacheable, h ? mc[idx] : 1'b0);
      chk("R5 fault", fault, h ? mfault(idx) : 2'd0);
    end
  endtask

  task automatic model_update();
    int v;
    bit full;
    if (flush) begin
      for (int i = 0; i < NE; i++) mv[i] = mv[i] & mg[i];
    end else if (inv_valid) begin
      for (int i = 0; i < NE; i++) if (mmatch(i, inv_vaddr)) mv[i] = 1'b0;
    end else if (rf_valid) begin
      v = -1;
      for (int i = NE - 1; i >= 0; i--) if (!mv[i]) v = i;
      full = (v < 0);
      if (full) begin
        v = rr;
        rr = (rr + 1) % NE;
      end
      mv[v] = 1'b1; mvpn[v] = rf_vaddr[31:12]; mbig[v] = rf_big; mppn[v] = rf_ppn;
      mc[v] = rf_c; mw[v] = rf_w; mx[v] = rf_x; mu[v] = rf_u; mg[v] = rf_g;
    end
  endtask

  task automatic cycle();
    @(negedge clk); #1;
    model_check();
    model_update();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    lk_req = 0; rf_valid = 0; inv_valid = 0; flush = 0;
  endtask

  task automatic do_fill(logic [31:0] va, logic big, logic [23:0] ppn, logic g);
    idle();
    rf_valid = 1; rf_vaddr = va; rf_big = big; rf_ppn = ppn;
    rf_c = 1; rf_w = 1; rf_x = 1; rf_u = 1; rf_g = g; rf_d = 0;
    cycle();
    idle();
  endtask

  task automatic expect_hit(logic [31:0] va, logic exp, string tag);
    idle();
    en = 1; lk_req = 1; lk_vaddr = va; lk_user = 0; lk_write = 0; lk_exec = 0;
    @(negedge clk); #1;
    chk(tag, hit, exp);
    idle();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] pg(int k);
    return 32'h0800_0000 | (k << 12);
  endfunction

  function automatic logic [31:0] pool_va();
    return {8'h40, 2'($urandom), 8'h00, 2'($urandom), 12'($urandom)};
  endfunction

  initial begin
    #(8 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: empty after reset
    en = 1; lk_req = 1; lk_vaddr = 32'h1234_5678;
    @(negedge clk); #1;
    chk("R1 hit", hit, 0);
    chk("R1 miss", miss, 1);
    idle();
    @(posedge clk); #1;

    // R10: fill all eight slots, the third is global
    for (int k = 0; k < NE; k++) do_fill(pg(k), 0, 24'h100 + k, k == 2);
    expect_hit(pg(0), 1, "R10 slot0 present");
    do_fill(pg(8), 0, 24'h200, 0);
    expect_hit(pg(0), 0, "R10 round-robin evicts slot0");
    expect_hit(pg(1), 1, "R10 slot1 kept");
    do_fill(pg(9), 0, 24'h201, 0);
    expect_hit(pg(1), 0, "R10 pointer advanced to slot1");

    // R8: flush keeps the global entry only
    idle(); flush = 1; cycle(); idle();
    expect_hit(pg(2), 1, "R8 global survives");
    expect_hit(pg(3), 0, "R8 non-global dropped");

    // R9: invalidate removes even a global entry
    idle(); inv_valid = 1; inv_vaddr = pg(2) | 32'h0ABC; cycle(); idle();
    expect_hit(pg(2), 0, "R9 invalidated");

    // R3 via model: a 4 MB entry, then a lookup deep inside it
    do_fill(32'h8040_0000, 1, 24'hABCDEF, 0);
    en = 1; lk_req = 1; lk_vaddr = 32'h807F_F123; cycle(); idle();
    expect_hit(32'h8050_0000, 1, "R3 large page coverage");

    // R11: flush wins over refill, invalidate wins over refill
    idle(); flush = 1; rf_valid = 1; rf_vaddr = pg(20); rf_big = 0; rf_g = 1; cycle(); idle();
    expect_hit(pg(20), 0, "R11 refill ignored under flush");
    do_fill(pg(21), 0, 24'h321, 0);
    idle(); inv_valid = 1; inv_vaddr = pg(21); rf_valid = 1; rf_vaddr = pg(22); cycle(); idle();
    expect_hit(pg(22), 0, "R11 refill ignored under invalidate");
    expect_hit(pg(21), 0, "R11 invalidate applied");

    // R5: rights on a restricted page
    idle(); rf_valid = 1; rf_vaddr = pg(30); rf_big = 0; rf_ppn = 24'h77;
    rf_c = 0; rf_w = 0; rf_x = 0; rf_u = 0; rf_g = 0; rf_d = 1; cycle(); idle();
    en = 1; lk_req = 1; lk_vaddr = pg(30); lk_user = 1; lk_write = 1; lk_exec = 1; cycle();
    lk_user = 0; cycle();
    lk_write = 0; cycle();
    idle();

    // Random traffic
    for (int n = 0; n < 6000; n++) begin
      int r;
      idle();
      en       = ($urandom % 10) != 0;
      lk_req   = ($urandom % 5) != 0;
      lk_vaddr = pool_va();
      lk_user  = 1'($urandom); lk_write = 1'($urandom); lk_exec = 1'($urandom);
      r = $urandom % 100;
      flush     = (r < 2);
      inv_valid = (r >= 1 && r < 8);
      rf_valid  = (r >= 6 && r < 40);
      inv_vaddr = pool_va();
      rf_vaddr  = pool_va();
      rf_big    = ($urandom % 4) == 0;
      rf_ppn    = 24'($urandom);
      rf_c = 1'($urandom); rf_w = 1'($urandom); rf_x = 1'($urandom);
      rf_u = 1'($urandom); rf_g = ($urandom % 6) == 0; rf_d = 1'($urandom);
      cycle();
    end
    idle();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule